// File: doc/BRIEF.md
# Predicated Vector Reciprocal-Exponent Unit

This block processes a whole vector register in one step. It splits the source operand into lanes of half, single or double precision floating-point values. A two-bit size code, supplied with each operation, picks the lane width. For each lane whose governing predicate bit is set, the block produces a rough reciprocal: it inverts every bit of the exponent field and keeps the sign and fraction. A NaN is the one exception. It comes out quieted and keeps its payload.

Lanes whose predicate bit is clear take the old destination value, which the caller supplies alongside the source. The predicate is byte-granular, so only the bit at the lowest byte of each lane governs that lane. Size code 0 is reserved. It raises an undefined-operation flag and returns the old destination unchanged. The result and the flags are registered one clock after the input strobe.

Top module: `vec_recip_exp`

## Requirements
- R1: Size code 1 selects 16-bit lanes, code 2 selects 32-bit lanes and code 3 selects 64-bit lanes, that is 8 << code bits per lane. The vector holds VLEN / lane-width lanes, with lane e at bits [e*W +: W].
- R2: Size code 0 is reserved. It sets `undef_op` to 1 and makes `result` equal to `dst_old` for the whole vector. Legal codes clear `undef_op`.
- R3: In an active lane, a non-NaN value leaves with its exponent field bitwise inverted and its fraction field unchanged. An infinity therefore becomes a signed zero.
- R4: In every active lane the sign bit (the top bit of the lane) is copied unchanged.
- R5: A lane whose predicate bit is 0 leaves with the `dst_old` bits of that lane.
- R6: Lane e is governed by `pred[e*W/8]`. All other predicate bits have no effect.
- R7: A NaN input lane (exponent all ones, fraction non-zero) leaves with its exponent still all ones, its fraction ORed with the top fraction bit (the quiet bit), and its sign kept.
- R8: `out_valid` is 1 exactly one clock after a cycle with `in_valid` = 1. `result` and `undef_op` hold their value in cycles with `in_valid` = 0.
- R9: While `rst_n` is 0, `out_valid`, `undef_op` and `result` are all 0.
- R10: The lane fields, from the top bit down, are sign/exponent/fraction. Their widths are 1/5/10 for half precision, 1/8/23 for single and 1/11/52 for double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| size_code | input | 2 | Lane size select, 0 is reserved |
| src | input | VLEN | Source vector |
| dst_old | input | VLEN | Present destination contents, merged into inactive lanes |
| pred | input | VLEN/8 | Byte-granular predicate mask |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | VLEN | Merged result vector |
| undef_op | output | 1 | Reserved size code was seen |

## Verification
Random operands almost never hit a NaN or an infinity. Random masks also do not show whether the block reads the wrong predicate bit inside a wide lane. The stimulus therefore forces the exponent of many lanes to all ones, and sometimes also clears the fraction. It also drives masks that set only the predicate bits that govern no lane. Every legal size and the reserved code are each swept with hundreds of vectors against an arithmetic model.

// File: rtl/vec_recip_exp.sv
module vec_recip_exp #(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        size_code,
  input  logic [VLEN-1:0]   src,
  input  logic [VLEN-1:0]   dst_old,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   result,
  output logic              undef_op
);

  logic [2:0][VLEN-1:0] cand;

  for (genvar k = 0; k < 3; k++) begin : g_size
    localparam int EW = 16 << k;
    localparam int XW = (k == 0) ? 5 : ((k == 1) ? 8 : 11);
    localparam int FW = EW - 1 - XW;
    localparam int NE = VLEN / EW;
    for (genvar e = 0; e < NE; e++) begin : g_lane
      logic [EW-1:0] s;
      logic [EW-1:0] r;
      logic [XW-1:0] x;
      logic [FW-1:0] f;
      assign s = src[e*EW +: EW];
      assign x = s[EW-2 -: XW];
      assign f = s[FW-1:0];
      assign r = (&x && |f) ? {s[EW-1], x, f | (FW'(1) << (FW-1))}
                            : {s[EW-1], ~x, f};
      assign cand[k][e*EW +: EW] = pred[e*EW/8] ? r : dst_old[e*EW +: EW];
    end
  end

  logic [VLEN-1:0] nxt;
  always_comb begin
    case (size_code)
      2'd1:    nxt = cand[0];
      2'd2:    nxt = cand[1];
      2'd3:    nxt = cand[2];
      default: nxt = dst_old;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      undef_op  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt;
        undef_op <= (size_code == 2'd0);
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(undef_op)));
  a_r2_reserved_merges: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd0) |=> (undef_op && result == $past(dst_old)));
  a_r2_legal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code != 2'd0) |=> !undef_op);
  a_r5_all_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred == '0) |=> result == $past(dst_old));

endmodule

// File: tb/vec_recip_exp_tb_top.sv
module vec_recip_exp_tb_top;
  localparam int VLEN = 128;
  localparam int PB = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] size_code = 2'd0;
  logic [VLEN-1:0] src = '0, dst_old = '0, result;
  logic [PB-1:0] pred = '0;
  logic out_valid, undef_op;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  vec_recip_exp #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
    .src(src), .dst_old(dst_old), .pred(pred),
    .out_valid(out_valid), .result(result), .undef_op(undef_op));

  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] s,
      input logic [VLEN-1:0] d, input logic [PB-1:0] m, input int sz);
    logic [VLEN-1:0] o;
    int ew, xw, fw;
    logic [63:0] el, ex, fr, xm, fm;
    if (sz == 0) return d;
    o = d;
    ew = 8 << sz;
    xw = (sz == 1) ? 5 : ((sz == 2) ? 8 : 11);
    fw = ew - 1 - xw;
    xm = (64'd1 << xw) - 1;
    fm = (64'd1 << fw) - 1;
    for (int e = 0; e < VLEN / ew; e++) begin
      if (m[e*ew/8]) begin
        el = 64'(s >> (e*ew));
        ex = (el >> fw) & xm;
        fr = el & fm;
        if (ex == xm && fr != 0) fr = fr | (64'd1 << (fw-1));
        else ex = ex ^ xm;
        el = (((el >> (ew-1)) & 64'd1) << (ew-1)) | (ex << fw) | fr;
        for (int b = 0; b < ew; b++) o[e*ew+b] = el[b];
      end
    end
    return o;
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] act,
      input logic [VLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int sz, input logic [VLEN-1:0] s,
      input logic [VLEN-1:0] d, input logic [PB-1:0] m, input string tag);
    logic [VLEN-1:0] exp, held;
    exp = model(s, d, m, sz);
    @(negedge clk);
    size_code = 2'(sz); src = s; dst_old = d; pred = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, result, exp);
    check({tag, " R2 flag"}, {127'd0, undef_op}, {127'd0, sz == 0});
    check("R8 valid", {127'd0, out_valid}, 128'd1);
    held = result;
    src = ~s; dst_old = ~d; pred = ~m; size_code = 2'(sz + 1);
    @(negedge clk);
    check("R8 hold", result, held);
    check("R8 no valid", {127'd0, out_valid}, 128'd0);
  endtask

  function automatic logic [VLEN-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Force exponents to all ones on some lanes (NaN / infinity cases, R7, R3)
  function automatic logic [VLEN-1:0] spice(input logic [VLEN-1:0] s, input int sz);
    logic [VLEN-1:0] o;
    int ew, xw, fw;
    o = s;
    if (sz == 0) return o;
    ew = 8 << sz;
    xw = (sz == 1) ? 5 : ((sz == 2) ? 8 : 11);
    fw = ew - 1 - xw;
    for (int e = 0; e < VLEN / ew; e++) begin
      int r = int'($urandom % 4);
      if (r >= 2) for (int b = 0; b < xw; b++) o[e*ew+fw+b] = 1'b1;
      if (r == 3) for (int b = 0; b < fw; b++) o[e*ew+b] = 1'b0;
    end
    return o;
  endfunction

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 result", result, '0);
    check("R9 flags", {126'd0, out_valid, undef_op}, 128'd0);
    rst_n = 1'b1;
    // R3 R4 R10: half-precision 1.0 (0x3C00) -> 0x4000 inverted exponent; negative sign kept
    run(1, {8{16'hBC00}}, '0, '1, "R3 R4 R10 half");
    // R10 single infinity 0x7F800000 -> zero; double 1.0 -> 0x4000_0000_0000_0000
    run(2, {4{32'h7F80_0000}}, '0, '1, "R3 R10 single inf");
    run(3, {2{64'h3FF0_0000_0000_0000}}, '0, '1, "R3 R10 double");
    // R7 signalling NaN quieted
    run(2, {4{32'hFF80_0001}}, '0, '1, "R7 nan");
    // R6: only non-governing predicate bits set, nothing changes
    run(3, rnd(), rnd(), 16'hFEFE, "R6 ignored bits");
    run(2, rnd(), rnd(), 16'hEEEE, "R6 ignored bits");
    run(1, rnd(), rnd(), 16'hAAAA, "R6 ignored bits");
    // R5: no active lane
    run(3, rnd(), rnd(), '0, "R5 inactive");
    // Sweeps of every size code (R1, R2, R3, R4, R5, R7)
    for (int sz = 0; sz < 4; sz++)
      for (int i = 0; i < 300; i++)
        run(sz, spice(rnd(), sz), rnd(), PB'($urandom),
            sz == 0 ? "R2 reserved" : "R1 R3 R5 R7 sweep");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule